// File: doc/BRIEF.md
# Eight-Source Priority Interrupt Controller

This block gathers interrupt requests from eight sources and presents the most urgent one to a microcontroller. Four of the sources are general-purpose request lines and four are terminal-count strobes from counter/timers. Each source has its own mask bit and its own sensitivity setting. A level-sensitive source is pending only while its line is high. An edge-sensitive source latches a rising edge and keeps it until it is serviced.

Unmasked pending sources go through a fixed-priority encoder. The encoder drives a 3-bit vector and a single request line to the host. The host reads the vector by pulsing a read strobe. When it does, the latch of the source named by the vector is cleared in that same cycle, and no separate acknowledge write is needed.

Every request enters through one register stage. The vector the host sees during a read cycle is therefore computed only from state that is already settled. A request that arrives during the read cannot change the value returned or the source that gets cleared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source numbering: `usr_req_i[k]` is source k, and `tc_req_i[k]` is source 4+k. The vector reports the source number as a binary value.
- R2: Reset leaves every source masked and level-sensitive, with `irq_o`=0 and `vec_o`=0. A cycle with `cfg_we_i`=1 loads the mask bits from `cfg_mask_i` (1 = masked) and the sensitivity bits from `cfg_edge_i` (1 = edge, 0 = level). The new settings take effect from the next cycle.
- R3: A masked source never raises `irq_o` and is never reported in `vec_o`. An edge seen on a masked edge-sensitive source is still latched, and it is reported once the mask is removed.
- R4: A level-sensitive source becomes pending one cycle after its input is sampled high and stops being pending one cycle after it is sampled low. A vector read does not clear it while the input stays high.
- R5: An edge-sensitive source latches a 0-to-1 transition of its input one cycle after the high sample. The latch holds after the input falls, until a vector read clears it.
- R6: `irq_o` is 1 exactly when at least one unmasked source is pending. `vec_o` is the lowest-numbered such source, and source 0 has the highest priority. `vec_o` is 0 when none is pending.
- R7: A cycle with `vec_rd_i`=1 and `irq_o`=1 clears the edge latch of the source shown on `vec_o`, and no other latch. A read while `irq_o`=0 changes nothing.
- R8: The value returned and the source cleared by a read are those shown during the read cycle. A request that arrives in that cycle is reported from the next cycle. A new rising edge on the serviced source in the read cycle wins over the clear, so the source stays pending.
- R9: Setting an edge-sensitive source to level-sensitive discards its latched edge. Setting it back to edge-sensitive does not restore that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usr_req_i | input | 4 | General-purpose request lines (sources 0..3) |
| tc_req_i | input | 4 | Counter/timer terminal-count lines (sources 4..7) |
| cfg_we_i | input | 1 | Load the mask and sensitivity settings |
| cfg_mask_i | input | 8 | Mask bits, 1 = masked |
| cfg_edge_i | input | 8 | Sensitivity bits, 1 = edge, 0 = level |
| vec_rd_i | input | 1 | Host reads the vector this cycle |
| irq_o | output | 1 | Interrupt request to the host |
| vec_o | output | 3 | Highest-priority pending unmasked source |

## Verification
The critical coincidence is a vector read in the same cycle as a new rising edge. The edge can come either from a higher-priority source or from the very source being serviced. The bench raises that edge at the same time as the read strobe. It then expects three results: the serviced source is cleared, the higher-priority source is reported in the next cycle, and a serviced source that rose again in the read cycle is still pending afterwards. A read of a level-sensitive source with its input held high is also applied, and the source is expected to survive the clear.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  localparam logic MASK_RST  = 1'b1;
  localparam logic SENSE_RST = 1'b0;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int SRC_N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SRC_N-1:0] mask_d_i,
  input  logic [SRC_N-1:0] edge_d_i,
  output logic [SRC_N-1:0] mask_q_o,
  output logic [SRC_N-1:0] edge_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= {SRC_N{MASK_RST}};
      edge_q_o <= {SRC_N{SENSE_RST}};
    end else if (we_i) begin
      mask_q_o <= mask_d_i;
      edge_q_o <= edge_d_i;
    end
  end

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import prio_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);

  logic   lvl_q;
  logic   hit_q;
  logic   rise;
  sense_e mode;

  assign mode = sense_e'(edge_mode_i);
  assign rise = req_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      lvl_q <= req_i;
      // a new edge in the clear cycle wins; level mode drops the latch
      if (mode == SENSE_EDGE) hit_q <= (hit_q & ~clr_i) | rise;
      else                    hit_q <= 1'b0;
    end
  end

  assign pend_o = (mode == SENSE_EDGE) ? hit_q : lvl_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = W'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter  int USR_N = 4,
  parameter  int TC_N  = 4,
  localparam int SRC_N = USR_N + TC_N,
  localparam int VEC_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [USR_N-1:0] usr_req_i,
  input  logic [TC_N-1:0]  tc_req_i,
  input  logic             cfg_we_i,
  input  logic [SRC_N-1:0] cfg_mask_i,
  input  logic [SRC_N-1:0] cfg_edge_i,
  input  logic             vec_rd_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);

  logic [SRC_N-1:0] src_w;
  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] edge_q;
  logic [SRC_N-1:0] pend_w;
  logic [SRC_N-1:0] act_w;
  logic [SRC_N-1:0] clr_w;

  assign src_w = {tc_req_i, usr_req_i};

  irq_cfg_regs #(.SRC_N(SRC_N)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .mask_d_i (cfg_mask_i),
    .edge_d_i (cfg_edge_i),
    .mask_q_o (mask_q),
    .edge_q_o (edge_q)
  );

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    irq_src_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (src_w[g]),
      .edge_mode_i (edge_q[g]),
      .clr_i       (clr_w[g]),
      .pend_o      (pend_w[g])
    );
  end

  assign act_w = pend_w & ~mask_q;

  irq_prio_enc #(.N(SRC_N), .W(VEC_W)) u_enc (
    .req_i (act_w),
    .idx_o (vec_o),
    .any_o (irq_o)
  );

  // clear targets the vector shown in the read cycle; it depends only on registers
  always_comb begin
    clr_w = '0;
    if (vec_rd_i && irq_o) clr_w[vec_o] = 1'b1;
  end

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int SRC_N = 8,
  parameter int VEC_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SRC_N-1:0] src_i,
  input logic             cfg_we_i,
  input logic [SRC_N-1:0] cfg_mask_i,
  input logic [SRC_N-1:0] mask_i,
  input logic [SRC_N-1:0] edge_i,
  input logic [SRC_N-1:0] pend_i,
  input logic             vec_rd_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o
);

  a_r2_cfg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (mask_i == $past(cfg_mask_i)));

  a_r3_mask_never_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mask_i[vec_o]);

  a_r4_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & ~edge_i) == ($past(src_i) & ~edge_i)));

  a_r5_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_rd_i && !cfg_we_i) |=> (($past(pend_i & edge_i) & ~pend_i) == '0));

  a_r6_irq_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(pend_i & ~mask_i)));

  a_r6_none_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (((pend_i & ~mask_i) & ((SRC_N'(1) << vec_o) - SRC_N'(1))) == '0));

  a_r7_read_clears_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && irq_o && !cfg_we_i && edge_i[vec_o] && !src_i[vec_o])
    |=> !pend_i[$past(vec_o)]);

endmodule

bind prio_irq_ctrl prio_irq_chk #(.SRC_N(SRC_N), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_w),
  .cfg_we_i   (cfg_we_i),
  .cfg_mask_i (cfg_mask_i),
  .mask_i     (mask_q),
  .edge_i     (edge_q),
  .pend_i     (pend_w),
  .vec_rd_i   (vec_rd_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

  typedef struct {
    logic       irq;
    logic [2:0] vec;
    string      tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] usr_req_i = '0;
  logic [3:0] tc_req_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_mask_i = '0;
  logic [7:0] cfg_edge_i = '0;
  logic       vec_rd_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .usr_req_i  (usr_req_i),
    .tc_req_i   (tc_req_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_mask_i (cfg_mask_i),
    .cfg_edge_i (cfg_edge_i),
    .vec_rd_i   (vec_rd_i),
    .irq_o      (irq_o),
    .vec_o      (vec_o)
  );

  // inputs change at posedge+2, expectations are pushed then, compared at posedge+5
  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic expect_out(logic irq, logic [2:0] vec, string tag);
    exp_t e;
    e.irq = irq;
    e.vec = vec;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cfg(logic [7:0] mask, logic [7:0] edg);
    cfg_mask_i = mask;
    cfg_edge_i = edg;
    cfg_we_i   = 1'b1;
    tick();
    cfg_we_i   = 1'b0;
  endtask

  task automatic rd();
    vec_rd_i = 1'b1;
    tick();
    vec_rd_i = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #5;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (irq_o !== e.irq || (e.irq && vec_o !== e.vec) || (!e.irq && vec_o !== 3'd0)) begin
          n_bad++;
          $display("FAIL %s: got irq=%0b vec=%0d, expected irq=%0b vec=%0d",
                   e.tag, irq_o, vec_o, e.irq, e.irq ? e.vec : 3'd0);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk_i);
    #2;
    rst_ni = 1'b1;
    expect_out(1'b0, 3'd0, "R2 reset state");
    tick();

    // R3/R2: reset leaves source 0 masked
    usr_req_i = 4'b0001;
    tick();
    expect_out(1'b0, 3'd0, "R3 masked after reset");
    cfg(8'h00, 8'h00);
    expect_out(1'b1, 3'd0, "R2 unmask level src0");

    // R6/R1 priority between user and tc lines
    tc_req_i = 4'b0100;
    tick();
    expect_out(1'b1, 3'd0, "R6 src0 beats src6");
    usr_req_i = 4'b0000;
    tick();
    expect_out(1'b1, 3'd6, "R1 tc line 2 is src6");
    tc_req_i = 4'b0000;
    tick();
    expect_out(1'b0, 3'd0, "R4 level drops");

    // R4 read does not clear a held level
    usr_req_i = 4'b0010;
    tick();
    expect_out(1'b1, 3'd1, "R4 level src1");
    rd();
    expect_out(1'b1, 3'd1, "R4 read keeps high level");
    usr_req_i = 4'b0000;
    tick();
    expect_out(1'b0, 3'd0, "R4 level released");

    // R5/R7 edge latching and clearing
    cfg(8'h00, 8'hFF);
    expect_out(1'b0, 3'd0, "R2 edge mode idle");
    usr_req_i = 4'b1000;
    tick();
    expect_out(1'b1, 3'd3, "R5 edge latched src3");
    usr_req_i = 4'b0000;
    tick();
    expect_out(1'b1, 3'd3, "R5 held after input low");
    tc_req_i = 4'b0001;
    tick();
    expect_out(1'b1, 3'd3, "R6 src3 beats src4");
    tc_req_i = 4'b0000;
    rd();
    expect_out(1'b1, 3'd4, "R7 only served src3 cleared");
    rd();
    expect_out(1'b0, 3'd0, "R7 src4 cleared");
    rd();
    expect_out(1'b0, 3'd0, "R7 idle read no effect");

    // R3 masked edge still latched
    cfg(8'h01, 8'hFF);
    usr_req_i = 4'b0001;
    tick();
    expect_out(1'b0, 3'd0, "R3 masked edge hidden");
    usr_req_i = 4'b0000;
    cfg(8'h00, 8'hFF);
    expect_out(1'b1, 3'd0, "R3 latched edge revealed");
    rd();
    expect_out(1'b0, 3'd0, "R7 revealed edge cleared");

    // R8 higher request arrives during the read
    usr_req_i = 4'b0100;
    tick();
    expect_out(1'b1, 3'd2, "R8 src2 pending");
    usr_req_i = 4'b0101;
    rd();
    expect_out(1'b1, 3'd0, "R8 new src0 shown after read");
    rd();
    expect_out(1'b0, 3'd0, "R8 frozen source stayed cleared");
    usr_req_i = 4'b0000;
    tick();
    expect_out(1'b0, 3'd0, "R8 idle");

    // R8 new edge on the served source wins over the clear
    usr_req_i = 4'b0010;
    tick();
    expect_out(1'b1, 3'd1, "R8 src1 first edge");
    usr_req_i = 4'b0000;
    tick();
    expect_out(1'b1, 3'd1, "R5 src1 held");
    usr_req_i = 4'b0010;
    rd();
    expect_out(1'b1, 3'd1, "R8 re-latched in read cycle");
    usr_req_i = 4'b0000;
    tick();
    expect_out(1'b1, 3'd1, "R8 re-latch persists");
    rd();
    expect_out(1'b0, 3'd0, "R7 src1 cleared");

    // R9 switching to level discards the latch
    usr_req_i = 4'b1000;
    tick();
    expect_out(1'b1, 3'd3, "R9 src3 latched");
    usr_req_i = 4'b0000;
    tick();
    expect_out(1'b1, 3'd3, "R9 src3 held");
    cfg(8'h00, 8'hF7);
    expect_out(1'b0, 3'd0, "R9 level mode discards");
    cfg(8'h00, 8'hFF);
    expect_out(1'b0, 3'd0, "R9 edge not restored");

    // R1 every source alone
    for (int i = 0; i < 8; i++) begin
      {tc_req_i, usr_req_i} = 8'(1 << i);
      tick();
      {tc_req_i, usr_req_i} = 8'h00;
      expect_out(1'b1, 3'(i), "R1 single source index");
      rd();
      expect_out(1'b0, 3'd0, "R7 single source cleared");
    end

    tick();
    tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule